// File: doc/BRIEF.md
# Alarm Match Interrupt Controller

This block watches a running BCD time of day (day of month, hour, minute, second) and raises an alarm when that time reaches a programmed alarm. Each of the four alarm fields can be excluded from the comparison on its own. This allows the alarm to repeat every minute, every hour or every day, or to fire on a single date. The time counters sit outside the block. They present their current values on `cur_time` and pulse `sec_tick` once per second. A separate `slow_tick` strobe at 32 Hz times the interrupt pulse.

When every field that is not excluded matches at a seconds tick, the block sets a sticky alarm flag. It can also drive an interrupt pin. Software programs five byte registers through a simple write port: four alarm fields and one interrupt configuration byte. It clears the alarm with a single read strobe. The configuration byte selects three things: whether the pin is used at all, whether it gives a short timed pulse or holds until the alarm is read, and whether its active level is high or low.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset, all four alarm bytes and the configuration byte are 00h, the flag is 0 and the pin is 1. This means the pin is idle for an active-low setting, and an all-zero time at the first seconds tick sets the flag.
- R2: Bit 7 of an alarm byte is its exclude bit. A value of 1 leaves the field out of the match. A value of 0 compares bits 6:0 with bits 6:0 of the current field; bit 7 of the current field is never compared.
- R3: Matching is evaluated only on a cycle with `sec_tick` high. The flag becomes 1 in the cycle after a tick on which all included fields match, if the previous tick did not match.
- R4: A time that stays matching over consecutive ticks sets the flag only on the first of them. A non-matching tick re-arms the alarm.
- R5: The flag stays set until `flags_rd` is high for a cycle and then reads 0. A match event in the same cycle as `flags_rd` leaves the flag set.
- R6: Configuration bit 0 enables the pin. When it is 0, a match still sets the flag but the pin stays idle.
- R7: With bit 1 = 0 (level mode), the pin is active from the cycle after the event until the cycle after `flags_rd`, however many `slow_tick` strobes occur in between.
- R8: With bit 1 = 1 (pulse mode), the pin stays active through 6 `slow_tick` strobes after the event and returns to idle after the 7th.
- R9: In pulse mode, `flags_rd` ends the pulse early; the pin is idle in the next cycle.
- R10: Configuration bit 2 sets polarity. With 1 the pin is 1 when active and 0 when idle; with 0 the levels are reversed.
- R11: Write select codes 0, 1, 2 and 3 address the seconds, minutes, hours and date alarm bytes, and code 4 addresses the configuration byte. Codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_time | input | 32 | Current BCD time: [7:0] seconds, [15:8] minutes, [23:16] hours, [31:24] date |
| sec_tick | input | 1 | One-cycle strobe once per second |
| slow_tick | input | 1 | One-cycle strobe at 32 Hz for pulse timing |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select (0-3 alarm bytes, 4 configuration) |
| cfg_wr_data | input | 8 | Register write data |
| flags_rd | input | 1 | Flag read strobe; clears flag and pin |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_pin | output | 1 | Interrupt pin, polarity per configuration |

## Verification
The hardest cases involve history as well as the current time. A match fires only on a rising edge of the match condition, and the flag is sticky. Reaching a given event therefore needs a non-matching seconds tick first, and the table of time vectors is ordered so that repeated, masked and high-bit-set times follow one another. The same-cycle collision of a match tick with a flag read, and the exact 7th-strobe end of a pulse, are set up by directed sequences that line up the strobes on a chosen edge.

// File: rtl/alarm_irq_pkg.sv
`timescale 1ns/1ps
package alarm_irq_pkg;
    // Configuration byte layout: bit 0 enable, bit 1 pulse mode, bit 2 polarity
    localparam int CFG_W = 3;

    typedef struct packed {
        logic pol;    // 1: active high
        logic pulse;  // 1: timed pulse, 0: hold until read
        logic en;     // 1: pin enabled
    } irq_cfg_t;
endpackage

// File: rtl/alarm_field_cmp.sv
`timescale 1ns/1ps
module alarm_field_cmp #(
    parameter int FIELD_W = 8
) (
    input  logic [FIELD_W-1:0] alarm_val,
    input  logic [FIELD_W-1:0] now_val,
    output logic               hit
);
    localparam int EXCL_BIT = FIELD_W - 1;

    logic val_eq;

    always_comb begin
        val_eq = (alarm_val[EXCL_BIT-1:0] == now_val[EXCL_BIT-1:0]);
        hit    = alarm_val[EXCL_BIT] | val_eq;
    end

    // bit EXCL_BIT of the current time is not part of the comparison
    logic now_top_unused;
    assign now_top_unused = now_val[EXCL_BIT];
endmodule

// File: rtl/alarm_irq_drive.sv
`timescale 1ns/1ps
module alarm_irq_drive
    import alarm_irq_pkg::*;
#(
    parameter int PULSE_TICKS = 7,
    localparam int CNT_W      = $clog2(PULSE_TICKS + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fire,
    input  logic     clear,
    input  logic     slow_tick,
    input  irq_cfg_t cfg,
    output logic     irq_pin
);
    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
    } drv_state_t;

    drv_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clear) begin
            nxt_d.act = 1'b0;
            nxt_d.cnt = '0;
        end else if (cur_q.act && cfg.pulse && slow_tick) begin
            if (cur_q.cnt <= CNT_W'(1)) begin
                nxt_d.act = 1'b0;
                nxt_d.cnt = '0;
            end else begin
                nxt_d.cnt = cur_q.cnt - CNT_W'(1);
            end
        end
        if (fire && cfg.en) begin
            nxt_d.act = 1'b1;
            nxt_d.cnt = CNT_W'(PULSE_TICKS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign irq_pin = cur_q.act ? cfg.pol : ~cfg.pol;
endmodule

// File: rtl/alarm_irq_ctrl.sv
`timescale 1ns/1ps
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int NUM_FIELDS  = 4,
    parameter int FIELD_W     = 8,
    parameter int PULSE_TICKS = 7,
    localparam int SEL_W      = $clog2(NUM_FIELDS + 1),
    localparam int TIME_W     = NUM_FIELDS * FIELD_W,
    localparam int CNT_W      = $clog2(PULSE_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] cur_time,
    input  logic              sec_tick,
    input  logic              slow_tick,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_sel,
    input  logic [FIELD_W-1:0] cfg_wr_data,
    input  logic              flags_rd,
    output logic              alarm_flag,
    output logic              irq_pin
);
    typedef struct packed {
        logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm;
        irq_cfg_t                           cfg;
        logic                               prev_hit;
        logic                               flag;
    } ctrl_state_t;

    ctrl_state_t cur_q, nxt_d;

    logic [NUM_FIELDS-1:0] field_hit;
    logic                  all_hit;
    logic                  alarm_event;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        alarm_field_cmp #(.FIELD_W(FIELD_W)) u_cmp (
            .alarm_val (cur_q.alarm[g]),
            .now_val   (cur_time[g*FIELD_W +: FIELD_W]),
            .hit       (field_hit[g])
        );
    end

    always_comb begin
        nxt_d       = cur_q;
        all_hit     = &field_hit;
        alarm_event = sec_tick & all_hit & ~cur_q.prev_hit;

        if (cfg_wr_en) begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (cfg_wr_sel == SEL_W'(i)) nxt_d.alarm[i] = cfg_wr_data;
            end
            if (cfg_wr_sel == SEL_W'(NUM_FIELDS)) nxt_d.cfg = irq_cfg_t'(cfg_wr_data[CFG_W-1:0]);
        end

        if (sec_tick)    nxt_d.prev_hit = all_hit;
        if (flags_rd)    nxt_d.flag     = 1'b0;
        if (alarm_event) nxt_d.flag     = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    alarm_irq_drive #(.PULSE_TICKS(PULSE_TICKS)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (alarm_event),
        .clear     (flags_rd),
        .slow_tick (slow_tick),
        .cfg       (cur_q.cfg),
        .irq_pin   (irq_pin)
    );

    assign alarm_flag = cur_q.flag;
endmodule

// File: rtl/alarm_irq_checker.sv
`timescale 1ns/1ps
module alarm_irq_checker #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sec_tick,
    input logic             slow_tick,
    input logic             flags_rd,
    input logic             cfg_wr_en,
    input logic             alarm_flag,
    input logic             irq_pin,
    input logic             cfg_pol,
    input logic             cfg_pulse,
    input logic             cfg_en,
    input logic             irq_act,
    input logic [CNT_W-1:0] pulse_cnt,
    input logic             alarm_event
);
    // R3: the flag only rises after a seconds tick
    a_r3_flag_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(sec_tick));

    // R5: the flag holds without a read
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_flag && !flags_rd |=> alarm_flag);

    // R5: a read with no tick clears the flag
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rd && !sec_tick |=> !alarm_flag);

    // R9: a read with no tick leaves the pin idle
    a_r9_read_idles_pin: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rd && !sec_tick && !cfg_wr_en |=> irq_pin != cfg_pol);

    // R8: the last slow tick of a pulse ends it
    a_r8_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
        irq_act && cfg_pulse && slow_tick && pulse_cnt == CNT_W'(1)
            && !alarm_event && !flags_rd && !cfg_wr_en |=> !irq_act);

    // R6: a disabled pin never becomes active
    a_r6_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_act && !cfg_en |=> !irq_act);
endmodule

bind alarm_irq_ctrl alarm_irq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .slow_tick   (slow_tick),
    .flags_rd    (flags_rd),
    .cfg_wr_en   (cfg_wr_en),
    .alarm_flag  (alarm_flag),
    .irq_pin     (irq_pin),
    .cfg_pol     (cur_q.cfg.pol),
    .cfg_pulse   (cur_q.cfg.pulse),
    .cfg_en      (cur_q.cfg.en),
    .irq_act     (u_drive.cur_q.act),
    .pulse_cnt   (u_drive.cur_q.cnt),
    .alarm_event (alarm_event)
);

// File: tb/alarm_irq_ctrl_test.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cur_time;
    logic        sec_tick, slow_tick, cfg_wr_en, flags_rd;
    logic [2:0]  cfg_wr_sel;
    logic [7:0]  cfg_wr_data;
    logic        alarm_flag, irq_pin;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alarm_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .sec_tick(sec_tick),
        .slow_tick(slow_tick), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .flags_rd(flags_rd),
        .alarm_flag(alarm_flag), .irq_pin(irq_pin)
    );

    // {expected flag, time date_hour_min_sec}; alarm is sec 30, min 15, hour and date excluded
    localparam logic [32:0] VEC [7] = '{
        {1'b1, 32'h00_00_15_30},   // R3 first match
        {1'b0, 32'h00_00_15_30},   // R4 still matching
        {1'b0, 32'h00_00_15_31},   // R2 seconds differ
        {1'b1, 32'h05_23_15_30},   // R2 excluded fields differ
        {1'b0, 32'h00_00_16_30},   // R2 minutes differ
        {1'b1, 32'h80_80_95_B0},   // R2 current bit 7 ignored
        {1'b0, 32'h00_00_15_30}    // R4 still matching
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_time(input logic [31:0] t);
        @(negedge clk); cur_time = t; sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic read_flags();
        @(negedge clk); flags_rd = 1'b1;
        @(negedge clk); flags_rd = 1'b0;
    endtask

    task automatic slow(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk); cfg_wr_en = 1'b0;
    endtask

    task automatic fire();
        tick_time(32'h00_00_00_00);
        tick_time(32'h00_00_15_30);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cur_time = '0; sec_tick = 0; slow_tick = 0;
        cfg_wr_en = 0; cfg_wr_sel = '0; cfg_wr_data = '0; flags_rd = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flag after reset", 32'(alarm_flag), 32'd0);
        check("R1 pin after reset", 32'(irq_pin), 32'd1);

        tick_time(32'h00_00_00_00);
        check("R1 zero alarm matches zero time", 32'(alarm_flag), 32'd1);
        read_flags();

        wr(3'd0, 8'h30); wr(3'd1, 8'h15); wr(3'd2, 8'h80); wr(3'd3, 8'h80);
        tick_time(32'h00_00_00_00);
        read_flags();

        for (int i = 0; i < 7; i++) begin
            tick_time(VEC[i][31:0]);
            check("R2 R3 R4 table flag", 32'(alarm_flag), 32'(VEC[i][32]));
            check("R6 table pin idle while disabled", 32'(irq_pin), 32'd1);
            read_flags();
            check("R5 flag cleared by read", 32'(alarm_flag), 32'd0);
        end

        // R3: matching time without a tick
        tick_time(32'h00_00_00_00);
        @(negedge clk); cur_time = 32'h00_00_15_30;
        repeat (3) @(negedge clk);
        check("R3 no tick no flag", 32'(alarm_flag), 32'd0);

        // R5: event and read in the same cycle
        tick_time(32'h00_00_00_00);
        @(negedge clk); cur_time = 32'h00_00_15_30; sec_tick = 1'b1; flags_rd = 1'b1;
        @(negedge clk); sec_tick = 1'b0; flags_rd = 1'b0;
        check("R5 event wins over read", 32'(alarm_flag), 32'd1);
        read_flags();

        // R11: select code 5 ignored, configuration stays 00h
        wr(3'd5, 8'h07);
        fire();
        check("R11 unused select leaves pin disabled", 32'(irq_pin), 32'd1);
        check("R6 flag sets while pin disabled", 32'(alarm_flag), 32'd1);
        read_flags();

        // R7 / R10: level mode, active high
        wr(3'd4, 8'h05);
        check("R10 idle low for active high", 32'(irq_pin), 32'd0);
        fire();
        check("R7 level active", 32'(irq_pin), 32'd1);
        slow(10);
        check("R7 level holds over slow ticks", 32'(irq_pin), 32'd1);
        read_flags();
        check("R7 level cleared by read", 32'(irq_pin), 32'd0);

        // R8: pulse mode, active low
        wr(3'd4, 8'h03);
        check("R10 idle high for active low", 32'(irq_pin), 32'd1);
        fire();
        check("R8 pulse active", 32'(irq_pin), 32'd0);
        slow(6);
        check("R8 pulse after 6 slow ticks", 32'(irq_pin), 32'd0);
        slow(1);
        check("R8 pulse ends on 7th slow tick", 32'(irq_pin), 32'd1);
        check("R8 flag survives pulse end", 32'(alarm_flag), 32'd1);
        read_flags();

        // R9: read ends the pulse early
        fire();
        slow(2);
        check("R9 pulse mid way", 32'(irq_pin), 32'd0);
        read_flags();
        check("R9 read ends pulse", 32'(irq_pin), 32'd1);
        check("R9 flag cleared", 32'(alarm_flag), 32'd0);

        // R10: pulse active high
        wr(3'd4, 8'h07);
        fire();
        check("R10 pulse active high", 32'(irq_pin), 32'd1);
        slow(7);
        check("R10 pulse back to low idle", 32'(irq_pin), 32'd0);
        read_flags();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule